// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable cycle-level model of a synchronous static RAM that accepts a new read or write command on every rising clock edge. Reads and writes may follow each other in any order with no idle cycle between them. This works because write data is always supplied after the command, at the same delay at which read data comes back. With that timing, the shared data path is never asked to change direction early.

A static strap selects one of two latencies:

- **Flow-through:** read data appears in the cycle right after the command edge. The data for a write is taken one edge after its command.
- **Pipelined:** read data is registered and appears one edge later. The data for a write is taken two edges after its command.

An advance input continues the previous operation at the next address of a four-beat burst. A second strap, which is not registered, chooses whether that burst steps in wrapping-increment order or in XOR order. An asynchronous output enable gates the read-valid flag and zeroes the read data. This is the tri-state style of output. Each byte lane has its own write enable.

The block has no back-pressure. It never stalls and has no ready output, so the host must present a command on every edge, or hold the enable low for an idle cycle. Read results carry a valid flag that the host takes when it is high. The host has no way to refuse them.

Top module: `sram_zero_turn`

## Requirements
- R1: When `cmd_adv`=0 and `cmd_en`=1, the command type (`cmd_we`=1 write, 0 read), `cmd_addr` and `cmd_be` are captured on that rising edge and become the start of a new burst.
- R2: In flow-through mode (`mode_pipe`=0), a read captured at edge k drives `rd_valid`=1 and the addressed word on `rd_data` from edge k until edge k+1. A write captured at edge k takes `wr_data` at edge k+1.
- R3: In pipelined mode (`mode_pipe`=1), a read captured at edge k drives its word from edge k+1 until edge k+2. A write captured at edge k takes `wr_data` at edge k+2.
- R4: A write updates only the byte lanes whose bit in `cmd_be` is 1. Lane i occupies data bits [i*LANE_W +: LANE_W]. The other lanes keep their contents.
- R5: Any mix of reads and writes on consecutive edges returns, for every read, the contents left by all earlier commands, with no idle cycles inserted.
- R6: When `cmd_adv`=1, the previous operation (read, write or deselect) continues and `cmd_en`, `cmd_we` and `cmd_addr` are ignored. A write beat uses the `cmd_be` sampled with that beat.
- R7: On beat n of a burst (n = 1, 2 or 3, counted modulo 4), the address keeps the upper bits of the start address. Its two low bits are start+n modulo 4 when `order_ilv`=0, and start XOR n when `order_ilv`=1. `order_ilv` is used unregistered at the edge.
- R8: After a deselect (`cmd_en`=0, `cmd_adv`=0) at edge k, `rd_valid` is 0 from edge k in flow-through mode. In pipelined mode it stays valid for the preceding read until edge k+1 and is 0 after it.
- R9: While `oe`=0, `rd_valid` is 0 and `rd_data` is all zeros, without waiting for a clock edge. When `oe` returns to 1, the pending result reappears.
- R10: In pipelined mode, a read whose address matches the write captured on the previous edge returns that write's data in the enabled lanes and the old contents in the others.
- R11: While `rst_n` is low and after its release, before any read, `rd_valid` is 0 and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pipe | input | 1 | Static strap: 1 pipelined, 0 flow-through |
| order_ilv | input | 1 | Static strap: 1 XOR burst order, 0 wrapping increment |
| oe | input | 1 | Asynchronous output enable |
| cmd_en | input | 1 | Start a new command on this edge |
| cmd_we | input | 1 | Command type: 1 write, 0 read |
| cmd_adv | input | 1 | Continue the previous operation at the next burst address |
| cmd_addr | input | ADDR_W | Word address of a new command |
| cmd_be | input | LANES | Per-lane write enables, sampled with each command or beat |
| wr_data | input | LANES*LANE_W | Write data, one or two edges after its command |
| rd_data | output | LANES*LANE_W | Read data, all zeros when not valid |
| rd_valid | output | 1 | Read data is valid in this cycle |

## Verification
The main function is exercised with four kinds of stimulus:

- **A block of plain writes followed by reads:** this sets each latency apart from the other, since a read sampled one cycle off returns a neighbour's word.
- **Writes immediately followed by reads of the same word, some with only one lane enabled:** these tell a correct forward of the pending write from a read of stale array contents, and a correct lane merge from a whole-word overwrite.
- **Bursts of reads and writes started at different low addresses under both burst orders:** the two orders give different address sequences for an odd start, so a swapped or misdecoded order shows up.
- **An advance issued after a deselect, and an advance with contradictory enable and address inputs:** these show whether the continuation tracks the previous operation or wrongly looks at new inputs.

// File: rtl/sram_zt_pkg.sv
package sram_zt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits of a burst beat: wrapping add or XOR with the beat count
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] n,
                                          input logic       xor_order);
    logic [1:0] r;
    r = xor_order ? (start ^ n) : (start + n);
    return r;
  endfunction

endpackage

// File: rtl/sram_zt_cmd.sv
module sram_zt_cmd
  import sram_zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  logic              cmd_we,
  input  logic              cmd_adv,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_be,
  input  logic              order_ilv,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  be_q
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;
  logic [ADDR_W-1:0] beat_addr;

  assign cnt_nx    = cnt_q + 2'd1;
  assign beat_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_nx, order_ilv)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      be_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (cmd_adv) begin
      // continue whatever ran last, including a deselect
      cnt_q  <= cnt_nx;
      addr_q <= beat_addr;
      be_q   <= cmd_be;
    end else if (cmd_en) begin
      op_q   <= cmd_we ? OP_WR : OP_RD;
      base_q <= cmd_addr;
      addr_q <= cmd_addr;
      be_q   <= cmd_be;
      cnt_q  <= '0;
    end else begin
      op_q   <= OP_IDLE;
    end
  end

  p_new_cmd_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_adv && cmd_en) |=> (addr_q == $past(cmd_addr)));

  p_adv_keeps_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_adv |=> (op_q == $past(op_q)));

  p_burst_in_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_adv && op_q != OP_IDLE) |=> (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2])));

endmodule

// File: rtl/sram_zt_wrq.sv
module sram_zt_wrq
  import sram_zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pipe,
  input  op_e               op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  be_in,
  output op_e               wop,
  output logic [ADDR_W-1:0] waddr,
  output logic [LANES-1:0]  wbe
);

  op_e               op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  be_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_d   <= OP_IDLE;
      addr_d <= '0;
      be_d   <= '0;
    end else begin
      op_d   <= op_in;
      addr_d <= addr_in;
      be_d   <= be_in;
    end
  end

  // The command whose data is on wr_data at the coming edge
  assign wop   = mode_pipe ? op_d   : op_in;
  assign waddr = mode_pipe ? addr_d : addr_in;
  assign wbe   = mode_pipe ? be_d   : be_in;

endmodule

// File: rtl/sram_zt_array.sv
module sram_zt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_q
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_q[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/sram_zt_rdpath.sv
module sram_zt_rdpath
  import sram_zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_pipe,
  input  logic                    oe,
  input  op_e                     rd_op,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  op_e                     wop,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES*LANE_W-1:0] arr_q,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);

  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] hold_q;
  logic              hold_v;
  logic              hit;
  logic [DATA_W-1:0] data_int;
  logic              valid_int;

  assign hit = (wop == OP_WR) && (waddr == rd_addr);

  // Forward the write whose data arrives at the same edge as this read lands
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] = (hit && wbe[g]) ? wr_data[g*LANE_W +: LANE_W]
                                                        : arr_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else begin
      hold_q <= merged;
      hold_v <= (rd_op == OP_RD);
    end
  end

  assign valid_int = mode_pipe ? hold_v : (rd_op == OP_RD);
  assign data_int  = mode_pipe ? hold_q : arr_q;
  assign rd_valid  = oe & valid_int;
  assign rd_data   = rd_valid ? data_int : '0;

  p_flow_read_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pipe && rd_op == OP_RD && oe) |-> rd_valid);

  p_pipe_read_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pipe && rd_op == OP_RD) |=> (rd_valid || !oe));

  p_bypass_lane0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pipe && rd_op == OP_RD && wop == OP_WR && waddr == rd_addr && wbe[0])
      |=> (!oe || rd_data[LANE_W-1:0] == $past(wr_data[LANE_W-1:0])));

endmodule

// File: rtl/sram_zero_turn.sv
module sram_zero_turn
  import sram_zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_pipe,
  input  logic                    order_ilv,
  input  logic                    oe,
  input  logic                    cmd_en,
  input  logic                    cmd_we,
  input  logic                    cmd_adv,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LANES-1:0]        cmd_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);

  localparam int DATA_W = LANES * LANE_W;

  op_e               cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  cur_be;
  op_e               wop;
  logic [ADDR_W-1:0] waddr;
  logic [LANES-1:0]  wbe;
  logic [DATA_W-1:0] arr_q;

  sram_zt_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_en    (cmd_en),
    .cmd_we    (cmd_we),
    .cmd_adv   (cmd_adv),
    .cmd_addr  (cmd_addr),
    .cmd_be    (cmd_be),
    .order_ilv (order_ilv),
    .op_q      (cur_op),
    .addr_q    (cur_addr),
    .be_q      (cur_be)
  );

  sram_zt_wrq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wrq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pipe (mode_pipe),
    .op_in     (cur_op),
    .addr_in   (cur_addr),
    .be_in     (cur_be),
    .wop       (wop),
    .waddr     (waddr),
    .wbe       (wbe)
  );

  sram_zt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_en   (wop == OP_WR),
    .wr_addr (waddr),
    .wr_be   (wbe),
    .wr_data (wr_data),
    .rd_addr (cur_addr),
    .rd_q    (arr_q)
  );

  sram_zt_rdpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pipe (mode_pipe),
    .oe        (oe),
    .rd_op     (cur_op),
    .rd_addr   (cur_addr),
    .wop       (wop),
    .waddr     (waddr),
    .wbe       (wbe),
    .wr_data   (wr_data),
    .arr_q     (arr_q),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: tb/tb_sram_zero_turn.sv
module tb_sram_zero_turn;

  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int NV = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_pipe = 1'b0;
  logic          order_ilv = 1'b0;
  logic          oe = 1'b1;
  logic          cmd_en = 1'b0;
  logic          cmd_we = 1'b0;
  logic          cmd_adv = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [NB-1:0] cmd_be = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  always #4 clk = ~clk;

  sram_zero_turn #(.ADDR_W(AW), .LANES(NB), .LANE_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .order_ilv(order_ilv), .oe(oe),
    .cmd_en(cmd_en), .cmd_we(cmd_we), .cmd_adv(cmd_adv), .cmd_addr(cmd_addr),
    .cmd_be(cmd_be), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // {en, we, adv, addr[5:0], be[1:0], data[17:0]}
  localparam logic [28:0] TBL [NV] = '{
    {3'b110, 6'h10, 2'b11, 18'h12345},
    {3'b110, 6'h11, 2'b11, 18'h0AAAA},
    {3'b110, 6'h12, 2'b11, 18'h15555},
    {3'b110, 6'h13, 2'b11, 18'h3C3C3},
    {3'b100, 6'h10, 2'b00, 18'h00000},
    {3'b110, 6'h11, 2'b01, 18'h3FFFF},
    {3'b100, 6'h11, 2'b00, 18'h00000},
    {3'b110, 6'h12, 2'b10, 18'h00000},
    {3'b100, 6'h12, 2'b00, 18'h00000},
    {3'b100, 6'h13, 2'b00, 18'h00000},
    {3'b110, 6'h20, 2'b11, 18'h2468A},
    {3'b100, 6'h20, 2'b00, 18'h00000},
    {3'b000, 6'h00, 2'b00, 18'h00000},
    {3'b100, 6'h11, 2'b00, 18'h00000},
    {3'b001, 6'h00, 2'b00, 18'h00000},
    {3'b001, 6'h00, 2'b00, 18'h00000},
    {3'b001, 6'h00, 2'b00, 18'h00000},
    {3'b110, 6'h30, 2'b11, 18'h11111},
    {3'b001, 6'h00, 2'b11, 18'h22222},
    {3'b001, 6'h00, 2'b11, 18'h33333},
    {3'b001, 6'h00, 2'b11, 18'h04444},
    {3'b100, 6'h32, 2'b00, 18'h00000},
    {3'b001, 6'h00, 2'b00, 18'h00000},
    {3'b001, 6'h00, 2'b00, 18'h00000},
    {3'b001, 6'h00, 2'b00, 18'h00000},
    {3'b000, 6'h00, 2'b00, 18'h00000},
    {3'b001, 6'h00, 2'b00, 18'h00000},
    {3'b100, 6'h30, 2'b00, 18'h00000}
  };

  logic [DW-1:0] rmem [64];

  function automatic string tag_of(input int k);
    case (k)
      4:                          return "R1";
      6:                          return "R10";
      8:                          return "R4";
      13, 14, 15, 16, 22, 23, 24: return "R7";
      18, 19, 20, 26:             return "R6";
      default:                    return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pipe, input logic ilv);
    rst_n = 1'b0; mode_pipe = pipe; order_ilv = ilv; oe = 1'b1;
    cmd_en = 0; cmd_we = 0; cmd_adv = 0; cmd_addr = '0; cmd_be = '0;
    repeat (2) @(posedge clk);
    #2;
    chk("R11 valid in reset", {17'd0, rd_valid}, '0);
    rst_n = 1'b1;
    #1;
    chk("R11 valid after release", {17'd0, rd_valid}, '0);
  endtask

  task automatic cmd(input logic [2:0] ctl, input logic [AW-1:0] a,
                     input logic [NB-1:0] b, input logic [DW-1:0] wd);
    {cmd_en, cmd_we, cmd_adv} = ctl;
    cmd_addr = a; cmd_be = b; wr_data = wd;
    @(posedge clk);
    #2;
  endtask

  task automatic run_table(input logic pipe, input logic ilv);
    int            lat;
    logic          ev [NV+2];
    logic [DW-1:0] ed [NV+2];
    logic          wset [NV+4];
    logic [DW-1:0] wd [NV+4];
    int            m_op;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    lat = pipe ? 2 : 1;
    m_op = 0; m_base = '0; m_cnt = '0;
    for (int i = 0; i < NV + 4; i++) begin wset[i] = 0; wd[i] = '0; end
    do_reset(pipe, ilv);
    for (int j = 0; j < NV + lat; j++) begin
      logic [28:0]   v;
      logic [AW-1:0] a;
      v = (j < NV) ? TBL[j] : 29'd0;
      a = v[25:20];
      if (v[26]) begin
        m_cnt = m_cnt + 2'd1;
        a = {m_base[AW-1:2], ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
      end else if (v[28]) begin
        m_op = v[27] ? 2 : 1; m_base = a; m_cnt = '0;
      end else begin
        m_op = 0;
      end
      if (j < NV) begin
        ev[j] = (m_op == 1);
        ed[j] = rmem[a];
        if (m_op == 2) begin
          if (v[18]) rmem[a][BW-1:0]    = v[BW-1:0];
          if (v[19]) rmem[a][DW-1:BW]   = v[DW-1:BW];
          wset[j+lat] = 1; wd[j+lat] = v[17:0];
        end
      end
      cmd(v[28:26], v[25:20], v[19:18], wset[j] ? wd[j] : (18'h2AAAA ^ DW'(j)));
      if (j - (lat - 1) >= 0 && j - (lat - 1) < NV) begin
        int k;
        k = j - (lat - 1);
        chk(tag_of(k), {17'd0, rd_valid}, {17'd0, ev[k]});
        if (ev[k]) chk(tag_of(k), rd_data, ed[k]);
      end
    end
  endtask

  initial begin
    logic [DW-1:0] m6;
    run_table(1'b0, 1'b0);
    run_table(1'b1, 1'b1);
    run_table(1'b1, 1'b0);
    run_table(1'b0, 1'b1);

    // R2 flow-through: read right after the write, data one edge after its command
    do_reset(1'b0, 1'b0);
    cmd(3'b110, 6'h05, 2'b11, 18'h3FFFF);
    cmd(3'b100, 6'h05, 2'b00, 18'h0ABCD);
    chk("R2 flow valid", {17'd0, rd_valid}, 18'd1);
    chk("R2 flow data", rd_data, 18'h0ABCD);
    cmd(3'b000, 6'h00, 2'b00, 18'h0);
    chk("R8 flow deselect", {17'd0, rd_valid}, '0);

    // R3 pipelined: data two edges after the write, read lands one edge late
    do_reset(1'b1, 1'b0);
    cmd(3'b110, 6'h06, 2'b11, 18'h0);
    cmd(3'b000, 6'h00, 2'b00, 18'h0);
    cmd(3'b000, 6'h00, 2'b00, 18'h15A5A);
    cmd(3'b100, 6'h06, 2'b00, 18'h0);
    chk("R3 pipe not yet valid", {17'd0, rd_valid}, '0);
    cmd(3'b000, 6'h00, 2'b00, 18'h0);
    chk("R3 pipe valid", {17'd0, rd_valid}, 18'd1);
    chk("R3 pipe data", rd_data, 18'h15A5A);
    cmd(3'b000, 6'h00, 2'b00, 18'h0);
    chk("R8 pipe floats second cycle", {17'd0, rd_valid}, '0);

    // R9 output enable
    cmd(3'b100, 6'h06, 2'b00, 18'h0);
    cmd(3'b000, 6'h00, 2'b00, 18'h0);
    oe = 1'b0;
    #1;
    chk("R9 oe low valid", {17'd0, rd_valid}, '0);
    chk("R9 oe low data", rd_data, '0);
    oe = 1'b1;
    #1;
    chk("R9 oe back", rd_data, 18'h15A5A);

    // R10 bypass with upper lane only
    cmd(3'b110, 6'h06, 2'b10, 18'h0);
    cmd(3'b100, 6'h06, 2'b00, 18'h0);
    cmd(3'b000, 6'h00, 2'b00, 18'h3FFFF);
    m6 = {9'h1FF, 9'(18'h15A5A)};
    chk("R10 bypass merge", rd_data, m6);

    // R6 advance ignores enable, type and address
    do_reset(1'b0, 1'b0);
    cmd(3'b100, 6'h05, 2'b00, 18'h0);
    chk("R6 start read", rd_data, 18'h0ABCD);
    cmd(3'b011, 6'h3F, 2'b11, 18'h0);
    chk("R6 adv continues read valid", {17'd0, rd_valid}, 18'd1);
    chk("R6 adv continues read data", rd_data, m6);
    cmd(3'b000, 6'h00, 2'b00, 18'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule